// File: doc/BRIEF.md
# Up/Down Digital Potentiometer Controller

This block is the digital control section of a 32-tap digitally controlled potentiometer. A host drives three asynchronous lines: an active-low select, a direction level and a step strobe. The block brings these lines into the system clock domain. While the block is selected, each falling edge of the step strobe moves a wiper position by one tap. The position stops at both ends and does not wrap. A registered one-hot word, one bit per tap, tells the analog switch network which tap to connect.

When the host releases the select line, the level of the step line at that moment decides the outcome. If the step line is high, the current position is written into a nonvolatile shadow register. If it is low, nothing is written and the new position stays live until it is moved again or the block is reset. A write starts a busy interval of a set number of clocks that stands in for the program time of the cell. A counter of writes lets the host track endurance use.

The shadow register survives the warm reset `rst` and loses its content only on the cold power-on `por`. On either reset the position is reloaded from the shadow register. A cold start first sets the shadow register to a parameter default.

Top module: `dpot_ctrl`

## Requirements
- R1: While `por` is high, and in the cycle after it, `pos` equals `NV_DEFAULT` (default 0), the shadow register is set to `NV_DEFAULT`, `store_cnt` is 0 and `busy` is 0.
- R2: While selected (`sel_n` low), a falling edge of `step` with `dir_up` high raises `pos` by one.
- R3: While selected, a falling edge of `step` with `dir_up` low lowers `pos` by one.
- R4: `pos` saturates: a step up at 31 leaves 31, and a step down at 0 leaves 0.
- R5: While `sel_n` is high, edges on `step` leave `pos` unchanged.
- R6: A rising edge of `sel_n` while `step` is high copies `pos` into the shadow register, adds one to `store_cnt`, and holds `busy` high for exactly `STORE_CYC` clocks.
- R7: A rising edge of `sel_n` while `step` is low writes nothing. `store_cnt` stays the same and `pos` keeps its new value.
- R8: A pulse on `rst` reloads `pos` from the shadow register. `store_cnt` keeps its value.
- R9: `tap_sel` has exactly one bit set, and that bit's index equals `pos`.
- R10: While `busy` is high, falling edges of `step` leave `pos` unchanged, even when the block is selected.
- R11: If the rise of `sel_n` and the fall of `step` fall in the same synchronised cycle, the position does not move and nothing is written.
- R12: `dir_up` may change between steps within one selection, and each step follows the level `dir_up` has at that step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Warm reset, synchronous, active high; keeps the shadow register |
| por | input | 1 | Cold power-on reset, synchronous, active high; clears the shadow register to the default |
| sel_n | input | 1 | Active-low select, asynchronous |
| dir_up | input | 1 | Step direction, asynchronous: 1 = up, 0 = down |
| step | input | 1 | Step strobe, asynchronous; acts on its falling edge |
| pos | output | POS_W | Current wiper position |
| tap_sel | output | TAPS | One-hot tap enable, registered |
| busy | output | 1 | High while a store interval runs |
| store_cnt | output | CNT_W | Number of stores since the cold power-on |

## Verification
The release of select and a falling edge of the step strobe can land in the same synchronised cycle. That cycle would both decide whether a store happens and ask for a move. The bench provokes this by changing `sel_n` and `step` on the same clock edge, so both lines pass through their synchronisers together. It then checks that `pos` and `store_cnt` are unchanged and that `busy` stays low. A following warm reset confirms that the shadow register still holds the earlier stored value. A second overlap, a step edge during an active store interval, is made by selecting the block again while `busy` is high.

// File: rtl/dpot_pkg.sv
`timescale 1ns/1ps
package dpot_pkg;
  // Control lines as one bundle, so they pass through a single synchroniser.
  typedef struct packed {
    logic sel_n;
    logic dir_up;
    logic step;
  } ctl_t;

  // Idle levels: deselected, direction down, strobe high.
  localparam ctl_t CTL_IDLE = '{sel_n: 1'b1, dir_up: 1'b0, step: 1'b1};
endpackage

// File: rtl/dpot_sync.sv
`timescale 1ns/1ps
module dpot_sync #(
  parameter int                W       = 3,
  parameter int                STAGES  = 2,
  parameter logic [W-1:0]      RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= RST_VAL;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= RST_VAL;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dpot_wiper.sv
`timescale 1ns/1ps
module dpot_wiper #(
  parameter int TAPS       = 32,
  parameter int CNT_W      = 16,
  parameter int STORE_CYC  = 1250000,
  parameter int NV_DEFAULT = 0,
  localparam int POS_W     = $clog2(TAPS),
  localparam int BW        = $clog2(STORE_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             por,
  input  logic             sel_s,
  input  logic             dir_s,
  input  logic             step_s,
  output logic [POS_W-1:0] pos,
  output logic [POS_W-1:0] pos_nxt,
  output logic             busy,
  output logic [CNT_W-1:0] store_cnt
);
  localparam logic [POS_W-1:0] TOP_POS = POS_W'(TAPS - 1);
  localparam logic [POS_W-1:0] DEF_POS = POS_W'(NV_DEFAULT);

  logic             sel_q, step_q;
  logic [POS_W-1:0] nv_q;
  logic [BW-1:0]    left_q;
  logic             move, release_edge, do_store;

  assign move         = !sel_s && step_q && !step_s && !busy;
  assign release_edge = sel_s && !sel_q;
  assign do_store     = release_edge && step_s && !busy;

  always_comb begin
    pos_nxt = pos;
    if (por)       pos_nxt = DEF_POS;
    else if (rst)  pos_nxt = nv_q;
    else if (move) begin
      if (dir_s) pos_nxt = (pos == TOP_POS) ? pos : pos + 1'b1;
      else       pos_nxt = (pos == '0)      ? pos : pos - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    pos <= pos_nxt;
    if (por || rst) begin
      sel_q  <= 1'b1;
      step_q <= 1'b1;
    end else begin
      sel_q  <= sel_s;
      step_q <= step_s;
    end
  end

  // Shadow register: only the cold reset touches it.
  always_ff @(posedge clk) begin
    if (por)           nv_q <= DEF_POS;
    else if (do_store) nv_q <= pos;
  end

  always_ff @(posedge clk) begin
    if (por)           store_cnt <= '0;
    else if (do_store) store_cnt <= store_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (por || rst) begin
      busy   <= 1'b0;
      left_q <= '0;
    end else if (do_store) begin
      busy   <= 1'b1;
      left_q <= BW'(STORE_CYC - 1);
    end else if (busy) begin
      if (left_q == '0) busy <= 1'b0;
      else              left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/dpot_decode.sv
`timescale 1ns/1ps
module dpot_decode #(
  parameter int TAPS   = 32,
  localparam int POS_W = $clog2(TAPS)
) (
  input  logic             clk,
  input  logic [POS_W-1:0] pos_nxt,
  output logic [TAPS-1:0]  tap_sel
);
  generate
    for (genvar i = 0; i < TAPS; i++) begin : g_tap
      always_ff @(posedge clk) tap_sel[i] <= (pos_nxt == POS_W'(i));
    end
  endgenerate
endmodule

// File: rtl/dpot_ctrl.sv
`timescale 1ns/1ps
module dpot_ctrl #(
  parameter int TAPS       = 32,
  parameter int CNT_W      = 16,
  parameter int STORE_CYC  = 1250000,
  parameter int NV_DEFAULT = 0,
  parameter int SYNC_STG   = 2,
  localparam int POS_W     = $clog2(TAPS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             por,
  input  logic             sel_n,
  input  logic             dir_up,
  input  logic             step,
  output logic [POS_W-1:0] pos,
  output logic [TAPS-1:0]  tap_sel,
  output logic             busy,
  output logic [CNT_W-1:0] store_cnt
);
  import dpot_pkg::*;

  ctl_t             raw, synced;
  logic [POS_W-1:0] pos_nxt;

  assign raw = '{sel_n: sel_n, dir_up: dir_up, step: step};

  dpot_sync #(.W($bits(ctl_t)), .STAGES(SYNC_STG), .RST_VAL(CTL_IDLE)) i_sync (
    .clk (clk),
    .rst (rst || por),
    .d   (raw),
    .q   (synced)
  );

  dpot_wiper #(.TAPS(TAPS), .CNT_W(CNT_W), .STORE_CYC(STORE_CYC),
               .NV_DEFAULT(NV_DEFAULT)) i_wiper (
    .clk       (clk),
    .rst       (rst),
    .por       (por),
    .sel_s     (synced.sel_n),
    .dir_s     (synced.dir_up),
    .step_s    (synced.step),
    .pos       (pos),
    .pos_nxt   (pos_nxt),
    .busy      (busy),
    .store_cnt (store_cnt)
  );

  dpot_decode #(.TAPS(TAPS)) i_decode (
    .clk     (clk),
    .pos_nxt (pos_nxt),
    .tap_sel (tap_sel)
  );
endmodule

// File: rtl/dpot_ctrl_chk.sv
`timescale 1ns/1ps
module dpot_ctrl_chk #(
  parameter int TAPS   = 32,
  parameter int CNT_W  = 16,
  localparam int POS_W = $clog2(TAPS)
) (
  input logic             clk,
  input logic             rst,
  input logic             por,
  input logic [POS_W-1:0] pos,
  input logic [TAPS-1:0]  tap_sel,
  input logic             busy,
  input logic [CNT_W-1:0] store_cnt
);
  p_tap_onehot_r9: assert property (@(posedge clk) disable iff (rst || por)
    ($countones(tap_sel) == 1) && tap_sel[pos]);

  p_unit_step_r2: assert property (@(posedge clk) disable iff (rst || por)
    !$past(rst || por) |->
      (pos == $past(pos)) || (int'(pos) == int'($past(pos)) + 1) ||
      (int'(pos) + 1 == int'($past(pos))));

  p_hold_busy_r10: assert property (@(posedge clk) disable iff (rst || por)
    busy |=> $stable(pos));

  p_store_bump_r6: assert property (@(posedge clk) disable iff (rst || por)
    (!$past(rst || por) && (store_cnt != $past(store_cnt))) |->
      (busy && (store_cnt == $past(store_cnt) + 1'b1)));

  p_cold_clear_r1: assert property (@(posedge clk) disable iff (rst)
    por |=> ((store_cnt == '0) && !busy));
endmodule

bind dpot_ctrl dpot_ctrl_chk #(.TAPS(TAPS), .CNT_W(CNT_W)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .por       (por),
  .pos       (pos),
  .tap_sel   (tap_sel),
  .busy      (busy),
  .store_cnt (store_cnt)
);

// File: tb/test_dpot_ctrl.sv
`timescale 1ns/1ps
module test_dpot_ctrl;
  localparam int TAPS      = 32;
  localparam int CNT_W     = 16;
  localparam int STORE_CYC = 40;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, por, sel_n, dir_up, step;
  logic [4:0]       pos;
  logic [TAPS-1:0]  tap_sel;
  logic             busy;
  logic [CNT_W-1:0] store_cnt;

  dpot_ctrl #(.TAPS(TAPS), .CNT_W(CNT_W), .STORE_CYC(STORE_CYC)) i_dpot_ctrl (
    .clk(clk), .rst(rst), .por(por), .sel_n(sel_n), .dir_up(dir_up), .step(step),
    .pos(pos), .tap_sel(tap_sel), .busy(busy), .store_cnt(store_cnt)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // {dir_up, expected pos} for steps within one selection, starting from 0.
  localparam logic [5:0] VEC [8] = '{
    6'b1_00001, 6'b1_00010, 6'b1_00011, 6'b0_00010,
    6'b0_00001, 6'b0_00000, 6'b0_00000, 6'b1_00001
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitn(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse();
    step = 1'b0; waitn(5);
    step = 1'b1; waitn(5);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    int nb;
    por = 1'b1; rst = 1'b0; sel_n = 1'b1; dir_up = 1'b0; step = 1'b1;
    waitn(4); por = 1'b0; waitn(2);
    check("R1 pos", pos, 0);
    check("R1 tap", tap_sel, 1);
    check("R1 busy", busy, 0);
    check("R1 count", store_cnt, 0);

    // R12: direction changes within one selection, table driven.
    sel_n = 1'b0; waitn(5);
    for (int i = 0; i < 8; i++) begin
      logic [4:0] prev;
      prev = (i == 0) ? 5'd0 : VEC[i-1][4:0];
      dir_up = VEC[i][5]; waitn(3);
      pulse();
      if (VEC[i][4:0] == prev) check("R4 floor", pos, VEC[i][4:0]);
      else if (VEC[i][5])      check("R2 up", pos, VEC[i][4:0]);
      else                     check("R3 down", pos, VEC[i][4:0]);
      check("R9 onehot", tap_sel, 32'd1 << VEC[i][4:0]);
    end

    // R4: climb past the top end.
    dir_up = 1'b1; waitn(3);
    for (int i = 0; i < 33; i++) pulse();
    check("R4 ceiling", pos, 31);
    check("R9 top tap", tap_sel, 32'h8000_0000);

    // R6: release with step high stores and runs the busy interval.
    sel_n = 1'b1; nb = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (busy) nb++;
    end
    check("R6 busy length", nb, STORE_CYC);
    check("R6 count", store_cnt, 1);

    // R5: steps while deselected are ignored.
    dir_up = 1'b0; waitn(3);
    pulse(); pulse();
    check("R5 deselected", pos, 31);

    // R7: release with step low stores nothing.
    sel_n = 1'b0; waitn(5);
    pulse(); pulse();
    step = 1'b0; waitn(5);
    sel_n = 1'b1; waitn(5);
    step = 1'b1; waitn(5);
    check("R7 pos kept", pos, 28);
    check("R7 count", store_cnt, 1);
    check("R7 busy", busy, 0);

    // R8: warm reset reloads the stored position.
    rst = 1'b1; waitn(2); rst = 1'b0; waitn(3);
    check("R8 reload", pos, 31);
    check("R8 count kept", store_cnt, 1);

    // R10: steps ignored during the store interval.
    sel_n = 1'b0; waitn(5);
    pulse();
    check("R3 down", pos, 30);
    sel_n = 1'b1; waitn(4);
    check("R6 busy set", busy, 1);
    sel_n = 1'b0; waitn(4);
    pulse();
    check("R10 pos held", pos, 30);
    check("R10 still busy", busy, 1);
    waitn(50);
    check("R6 busy done", busy, 0);
    check("R6 count", store_cnt, 2);
    pulse();
    check("R3 after busy", pos, 29);

    // R11: release and step fall in the same cycle.
    sel_n = 1'b1; step = 1'b0; waitn(6);
    check("R11 pos", pos, 29);
    check("R11 count", store_cnt, 2);
    check("R11 busy", busy, 0);
    step = 1'b1; waitn(3);
    rst = 1'b1; waitn(2); rst = 1'b0; waitn(3);
    check("R11 shadow kept", pos, 30);

    // R1: cold start clears the shadow register.
    por = 1'b1; waitn(2); por = 1'b0; waitn(2);
    check("R1 cold pos", pos, 0);
    check("R1 cold count", store_cnt, 0);
    rst = 1'b1; waitn(2); rst = 1'b0; waitn(3);
    check("R1 shadow default", pos, 0);
    check("R9 tap zero", tap_sel, 1);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule